// File: doc/BRIEF.md
# Radix Page Table Walker

The walker translates a 64-bit virtual address into a physical address by reading a radix tree held in memory, one 8-byte entry per step. A translation starts with a read of a per-process descriptor. That descriptor gives the base of the root table, the number of address bits the tree covers, and the index width of the root level. The walker then reads one entry per level and subtracts each level's index width from the remaining shift. It stops at a leaf, an invalid entry or a malformed size field.

A requester presents the virtual address, a process number, a load/store flag and the problem-state bit. The walker issues single-entry reads on a simple request/response memory port and never has more than one read outstanding. When it finishes, it reports a one-cycle result. The result carries either a physical address or a fault code, together with the access flags that came with the request. The walker takes a new request only when it is idle.

Top module: `radix_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1 and both `mem_req` and `res_valid` are 0. Each result is a single-cycle `res_valid` pulse, and `req_ready` returns to 1 in the following cycle.
- R2: An accepted request first reads the process descriptor at address `{ptab_base, 8'h00} | (req_pid << 3)`. Every read is a one-cycle `mem_req` pulse, after which the walker waits for `mem_rvalid`. Only one read is outstanding at a time.
- R3: In the process descriptor, bits 62:58 are the tree span, which becomes the initial 6-bit shift. Bits 4:0 are the root index width, and bits 55:8 followed by eight zero bits form the root table base. The next read address is `base | (index << 3)`, where `index` is the virtual-address bits [shift-1 : shift-width].
- R4: A walk ends with fault code 1 (bad tree) and issues no further read when a level width, zero-extended to 6 bits, is below 5, above 16, or larger than the remaining shift. This applies to the root width as well as to widths found in directory entries.
- R5: An entry fetched from a tree level with bit 63 clear ends the walk with fault code 2 (invalid) and issues no further read. The valid bit of the process descriptor is not examined.
- R6: A tree entry with bit 63 set and bit 62 clear is a directory. Its bits 4:0 give the next index width, its bits 55:8 shifted up by 8 give the next table base, and the remaining shift is reduced by that width at 6-bit precision.
- R7: A tree entry with bits 63 and 62 set is a leaf. The walk ends with fault code 0, and the physical address takes bits below the remaining shift from the virtual address and bits 57:0 of the leaf above it, with bits 63:58 zero. When any fault is reported, `res_paddr` is 0.
- R8: The result carries `res_store` equal to the request's store flag and `res_priv` equal to the inverse of the request's problem-state bit.
- R9: `mem_rvalid` has no effect unless the walker is waiting for a read, and `req_valid` has no effect while a walk is in progress (`req_ready` is 0).
- R10: The entry is decoded in the cycle after `mem_rvalid` is accepted. In the second cycle after acceptance, either the next `mem_req` or `res_valid` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptab_base | input | 56 | Process descriptor table base, address bits 63:8 |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted when `req_valid` is 1 |
| req_vaddr | input | 64 | Virtual address to translate |
| req_pid | input | PID_W | Process number selecting the descriptor |
| req_store | input | 1 | 1 for store access, 0 for load |
| req_problem | input | 1 | Problem-state bit of the requester |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | 64 | Byte address of the 8-byte entry to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read entry |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 2 | 0 none, 1 bad tree, 2 invalid entry |
| res_paddr | output | 64 | Translated physical address, 0 on fault |
| res_store | output | 1 | Store flag of the translated request |
| res_priv | output | 1 | Privilege of the translated request |

## Verification
The hardest cases to reach from the ports are the deep ones. These are a size fault found in a directory entry several levels down, and the boundary widths 5 and 16 that bring the remaining shift to exactly zero. Both are reached by building small trees in a sparse bench memory, so that a chosen virtual address lands on a chosen entry at a chosen level. Read responses that arrive while the walker is idle, and requests that arrive during a walk, are injected between walks. The next result then shows whether either of them disturbed the walker. Response latency varies from walk to walk, so decode timing is exercised for more than one delay.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_DEC, S_DONE} walk_state_e;
  typedef enum logic [1:0] {OUT_NEXT, OUT_LEAF, OUT_BAD, OUT_INV} outcome_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_BADTREE = 2'd1, FLT_INVALID = 2'd2} fault_e;

  // mask with the n low bits set
  function automatic logic [63:0] low_mask(input logic [5:0] n);
    return (64'd1 << n) - 64'd1;
  endfunction

  // index of a level: width m taken just below the remaining shift sh
  function automatic logic [63:0] level_index(input logic [63:0] va,
                                              input logic [5:0] sh,
                                              input logic [5:0] m);
    logic [5:0] lo;
    lo = sh - m;
    return (va >> lo) & low_mask(m);
  endfunction

  // width within limits and not larger than what remains to translate
  function automatic logic size_ok(input logic [5:0] m, input logic [5:0] sh,
                                   input logic [5:0] lo, input logic [5:0] hi);
    return (m >= lo) && (m <= hi) && (m <= sh);
  endfunction

  // leaf page number above the shift, offset from the virtual address below
  function automatic logic [63:0] leaf_paddr(input logic [57:0] rpn,
                                             input logic [63:0] va,
                                             input logic [5:0] sh);
    return ({6'd0, rpn} & ~low_mask(sh)) | (va & low_mask(sh));
  endfunction

endpackage

// File: rtl/radix_walk_decode.sv
module radix_walk_decode
  import radix_walk_pkg::*;
#(
  parameter int SZ_MIN = 5,
  parameter int SZ_MAX = 16
) (
  input  logic [5:0]  ent_hi,     // entry bits 63:58
  input  logic [47:0] ent_base,   // entry bits 55:8
  input  logic [4:0]  ent_size,   // entry bits 4:0
  input  logic        is_root,
  input  logic [5:0]  cur_shift,
  output outcome_e    outcome,
  output logic [5:0]  lvl_size,
  output logic [5:0]  eff_shift,
  output logic [5:0]  rem_shift,
  output logic [63:0] lvl_base
);
  localparam logic [5:0] SZ_LO = 6'(SZ_MIN);
  localparam logic [5:0] SZ_HI = 6'(SZ_MAX);

  logic ent_valid, ent_leaf;

  always_comb begin
    lvl_size  = {1'b0, ent_size};
    eff_shift = is_root ? {1'b0, ent_hi[4:0]} : cur_shift;
    rem_shift = eff_shift - lvl_size;
    lvl_base  = {8'h00, ent_base, 8'h00};
    ent_valid = is_root | ent_hi[5];
    ent_leaf  = !is_root & ent_hi[4];
    if (!ent_valid)                                  outcome = OUT_INV;
    else if (ent_leaf)                               outcome = OUT_LEAF;
    else if (!size_ok(lvl_size, eff_shift, SZ_LO, SZ_HI)) outcome = OUT_BAD;
    else                                             outcome = OUT_NEXT;
  end
endmodule

// File: rtl/radix_walk_index.sv
module radix_walk_index
  import radix_walk_pkg::*;
#(
  parameter int ENT_BYTES = 8
) (
  input  logic [63:0] va,
  input  logic [63:0] lvl_base,
  input  logic [5:0]  eff_shift,
  input  logic [5:0]  lvl_size,
  output logic [63:0] ent_addr
);
  localparam int ENT_LOG = $clog2(ENT_BYTES);

  always_comb
    ent_addr = lvl_base | (level_index(va, eff_shift, lvl_size) << ENT_LOG);
endmodule

// File: rtl/radix_walk_leaf.sv
module radix_walk_leaf
  import radix_walk_pkg::*;
(
  input  logic [57:0] rpn,
  input  logic [63:0] va,
  input  logic [5:0]  shift,
  output logic [63:0] paddr
);
  always_comb paddr = leaf_paddr(rpn, va, shift);
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import radix_walk_pkg::*;
#(
  parameter int PID_W  = 4,
  parameter int SZ_MIN = 5,
  parameter int SZ_MAX = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:8]      ptab_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [63:0]      req_vaddr,
  input  logic [PID_W-1:0] req_pid,
  input  logic             req_store,
  input  logic             req_problem,
  output logic             mem_req,
  output logic [63:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [63:0]      mem_rdata,
  output logic             res_valid,
  output logic [1:0]       res_fault,
  output logic [63:0]      res_paddr,
  output logic             res_store,
  output logic             res_priv
);
  localparam int ENT_BYTES = 8;
  localparam int ENT_LOG   = $clog2(ENT_BYTES);

  walk_state_e st;
  logic [63:0] va_q, addr_q, ent_q, pa_q;
  logic [5:0]  shift_q;
  logic        root_q, store_q, priv_q;
  fault_e      fault_q;

  outcome_e    outc;
  logic [5:0]  lvl_size, eff_shift, rem_shift;
  logic [63:0] lvl_base, nxt_addr, leaf_pa, desc_addr;

  // named events for the checker
  logic wait_st, dec_st, bad_evt, inv_evt;

  radix_walk_decode #(.SZ_MIN(SZ_MIN), .SZ_MAX(SZ_MAX)) u_dec (
    .ent_hi(ent_q[63:58]), .ent_base(ent_q[55:8]), .ent_size(ent_q[4:0]),
    .is_root(root_q), .cur_shift(shift_q), .outcome(outc),
    .lvl_size(lvl_size), .eff_shift(eff_shift), .rem_shift(rem_shift),
    .lvl_base(lvl_base)
  );

  radix_walk_index #(.ENT_BYTES(ENT_BYTES)) u_idx (
    .va(va_q), .lvl_base(lvl_base), .eff_shift(eff_shift),
    .lvl_size(lvl_size), .ent_addr(nxt_addr)
  );

  radix_walk_leaf u_leaf (
    .rpn(ent_q[57:0]), .va(va_q), .shift(shift_q), .paddr(leaf_pa)
  );

  always_comb begin
    desc_addr = {ptab_base, 8'h00} | (64'(req_pid) << ENT_LOG);
    wait_st   = (st == S_WAIT);
    dec_st    = (st == S_DEC);
    bad_evt   = dec_st && (outc == OUT_BAD);
    inv_evt   = dec_st && (outc == OUT_INV);
    req_ready = (st == S_IDLE);
    mem_req   = (st == S_REQ);
    mem_addr  = addr_q;
    res_valid = (st == S_DONE);
    res_fault = fault_q;
    res_paddr = pa_q;
    res_store = store_q;
    res_priv  = priv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      ent_q   <= '0;
      pa_q    <= '0;
      shift_q <= '0;
      root_q  <= 1'b0;
      store_q <= 1'b0;
      priv_q  <= 1'b0;
      fault_q <= FLT_NONE;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          store_q <= req_store;
          priv_q  <= ~req_problem;
          addr_q  <= desc_addr;
          root_q  <= 1'b1;
          st      <= S_REQ;
        end
        S_REQ:  st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          ent_q <= mem_rdata;
          st    <= S_DEC;
        end
        S_DEC: begin
          unique case (outc)
            OUT_NEXT: begin
              addr_q  <= nxt_addr;
              shift_q <= rem_shift;
              root_q  <= 1'b0;
              st      <= S_REQ;
            end
            OUT_LEAF: begin
              pa_q    <= leaf_pa;
              fault_q <= FLT_NONE;
              st      <= S_DONE;
            end
            OUT_BAD: begin
              pa_q    <= '0;
              fault_q <= FLT_BADTREE;
              st      <= S_DONE;
            end
            OUT_INV: begin
              pa_q    <= '0;
              fault_q <= FLT_INVALID;
              st      <= S_DONE;
            end
          endcase
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       mem_req,
  input logic       mem_rvalid,
  input logic       res_valid,
  input logic [1:0] res_fault,
  input logic       wait_st,
  input logic       dec_st,
  input logic       bad_evt,
  input logic       inv_evt
);
  // R1: result is a single pulse followed by idle
  a_r1_result_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (!res_valid && req_ready));

  // R2: read request lasts one cycle and is followed by waiting
  a_r2_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> (!mem_req && wait_st));

  // R4: size fault reported right after decode
  a_r4_bad_tree: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> (res_valid && res_fault == 2'd1));

  // R5: invalid entry reported right after decode
  a_r5_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    inv_evt |=> (res_valid && res_fault == 2'd2));

  // R9: idle walker stays idle without a request, whatever the response port does
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> req_ready);

  // R9: a response outside the wait state does not start a decode
  a_r9_stray_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_st && mem_rvalid) |=> !dec_st || !mem_rvalid || $past(wait_st));

  // R10: accepted response is decoded on the next cycle
  a_r10_decode_next: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_st && mem_rvalid) |=> dec_st);

  // R10: decode leads to a new read or a result
  a_r10_act_after_dec: assert property (@(posedge clk) disable iff (!rst_n)
    dec_st |=> (mem_req || res_valid));

  // R2: never a read and a result together
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && res_valid));
endmodule

bind radix_walker radix_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req(mem_req), .mem_rvalid(mem_rvalid), .res_valid(res_valid),
  .res_fault(res_fault), .wait_st(wait_st), .dec_st(dec_st),
  .bad_evt(bad_evt), .inv_evt(inv_evt)
);

// File: tb/sim_radix_walker.sv
module sim_radix_walker;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [63:8] ptab_base;
  logic        req_valid, req_ready, req_store, req_problem;
  logic [63:0] req_vaddr;
  logic [3:0]  req_pid;
  logic        mem_req, mem_rvalid;
  logic [63:0] mem_addr, mem_rdata;
  logic        res_valid, res_store, res_priv;
  logic [1:0]  res_fault;
  logic [63:0] res_paddr;

  radix_walker u0 (
    .clk(clk), .rst_n(rst_n), .ptab_base(ptab_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_pid(req_pid), .req_store(req_store), .req_problem(req_problem),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .res_valid(res_valid), .res_fault(res_fault),
    .res_paddr(res_paddr), .res_store(res_store), .res_priv(res_priv)
  );

  localparam logic [63:0] BASE_MASK = 64'h00FF_FFFF_FFFF_FF00;
  localparam logic [63:0] DESC_BASE = 64'h0000_0000_0001_0000;

  int n_tests = 0;
  int n_fail  = 0;
  int got_res = 0;
  int rd_n    = 0;
  int lat     = 1;
  logic spur_go = 1'b0;
  logic spur_done = 1'b0;
  logic finished = 1'b0;

  logic [63:0] bmem [logic [63:0]];
  logic [63:0] exp_addr [$];
  logic [1:0]  exp_fault;
  logic [63:0] exp_pa;
  logic        exp_store, exp_priv;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [63:0] a);
    return bmem.exists(a) ? bmem[a] : 64'd0;
  endfunction

  // table base of an entry plus index bits va[sh-1:sh-m] placed from bit 3 up
  function automatic logic [63:0] idx_addr(input logic [63:0] e, input logic [63:0] va,
                                           input int sh, input int m);
    logic [63:0] a;
    a = e & BASE_MASK;
    for (int i = 0; i < m; i++) a[3+i] = a[3+i] | va[sh-m+i];
    return a;
  endfunction

  function automatic logic [63:0] mk_desc(input int span, input logic [63:0] base, input int sz);
    return (64'(span & 31) << 58) | (base & BASE_MASK) | 64'(sz & 31);
  endfunction
  function automatic logic [63:0] mk_dir(input logic [63:0] base, input int sz);
    return 64'h8000_0000_0000_0000 | (base & BASE_MASK) | 64'(sz & 31);
  endfunction
  function automatic logic [63:0] mk_leaf(input logic [63:0] rpn);
    return 64'hC000_0000_0000_0000 | (rpn & 64'h03FF_FFFF_FFFF_FFFF);
  endfunction
  function automatic logic [63:0] desc_at(input int pid);
    return DESC_BASE | 64'(pid << 3);
  endfunction

  // behavioural reference walk
  task automatic run_model(input logic [63:0] va, input int pid);
    logic [63:0] a, e;
    int sh, m;
    bit fin, first;
    exp_addr.delete();
    exp_pa = 64'd0;
    exp_fault = 2'd0;
    a = desc_at(pid);
    exp_addr.push_back(a);
    e = rd(a);
    sh = int'(e[62:58]);
    m = 0;
    fin = 0;
    first = 1;
    for (int lvl = 0; lvl < 10 && !fin; lvl++) begin
      if (!first && !e[63]) begin
        exp_fault = 2'd2; fin = 1;
      end else if (!first && e[62]) begin
        for (int b = 0; b < 64; b++)
          exp_pa[b] = (b < sh) ? va[b] : ((b < 58) ? e[b] : 1'b0);
        exp_fault = 2'd0; fin = 1;
      end else begin
        m = int'(e[4:0]);
        if (m < 5 || m > 16 || m > sh) begin
          exp_fault = 2'd1; fin = 1;
        end else begin
          a = idx_addr(e, va, sh, m);
          exp_addr.push_back(a);
          sh = sh - m;
          e = rd(a);
          first = 0;
        end
      end
    end
  endtask

  // memory responder and per-read checks
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = 64'd0;
    @(negedge clk);
    forever begin
      if (mem_req) begin
        if (exp_addr.size() == 0) chk("R2 unexpected read", mem_addr, 64'hDEAD);
        else begin
          if (rd_n == 0)      chk("R2 descriptor address", mem_addr, exp_addr[0]);
          else if (rd_n == 1) chk("R3 root entry address", mem_addr, exp_addr[0]);
          else                chk("R6 next level address", mem_addr, exp_addr[0]);
          void'(exp_addr.pop_front());
        end
        rd_n++;
        mem_rdata = rd(mem_addr);
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          if (k == 0) chk("R2 one read pulse", {63'd0, mem_req}, 64'd0);
        end
        mem_rvalid = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0;
        @(negedge clk);
        chk("R10 act two cycles after response", {63'd0, mem_req | res_valid}, 64'd1);
      end else if (spur_go && !spur_done) begin
        mem_rdata = mk_leaf(64'h1234_5678);
        for (int k = 0; k < 3; k++) begin
          mem_rvalid = 1'b1;
          @(negedge clk);
        end
        mem_rvalid = 1'b0;
        spur_done = 1'b1;
      end else begin
        @(negedge clk);
      end
    end
  end

  // result monitor
  initial begin
    forever begin
      @(negedge clk);
      if (res_valid) begin
        if (exp_fault == 2'd1)      chk("R4 fault code", {62'd0, res_fault}, {62'd0, exp_fault});
        else if (exp_fault == 2'd2) chk("R5 fault code", {62'd0, res_fault}, {62'd0, exp_fault});
        else                        chk("R7 fault code", {62'd0, res_fault}, 64'd0);
        chk("R7 physical address", res_paddr, exp_pa);
        chk("R8 store flag", {63'd0, res_store}, {63'd0, exp_store});
        chk("R8 privilege", {63'd0, res_priv}, {63'd0, exp_priv});
        chk("R2 all reads issued", 64'(exp_addr.size()), 64'd0);
        got_res++;
      end
    end
  end

  task automatic walk(input logic [63:0] va, input int pid, input bit st,
                      input bit prob, input int l, input bit intrude);
    int seen;
    lat = l;
    run_model(va, pid);
    exp_store = st;
    exp_priv  = !prob;
    rd_n = 0;
    seen = got_res;
    @(negedge clk);
    req_vaddr = va; req_pid = 4'(pid); req_store = st; req_problem = prob;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 busy after accept", {63'd0, req_ready}, 64'd0);
    if (intrude) begin
      @(negedge clk);
      req_vaddr = ~va; req_pid = 4'(pid + 1); req_store = !st; req_problem = !prob;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait (got_res != seen);
    @(negedge clk);
    chk("R1 idle after result", {63'd0, req_ready}, 64'd1);
  endtask

  logic [63:0] va1, va2, va6, va7, e;

  initial begin
    rst_n = 1'b0;
    ptab_base = DESC_BASE[63:8] | 56'h05;   // low bits must not leak into addresses
    ptab_base = DESC_BASE[63:8];
    req_valid = 1'b0; req_vaddr = '0; req_pid = '0; req_store = 1'b0; req_problem = 1'b0;

    // tree for pid 1: span 30, widths 9 and 9
    va1 = 64'hFFFF_0000_2ABC_D123;
    bmem[desc_at(1)] = mk_desc(30, 64'h0500_0000, 9);
    e = mk_dir(64'h0600_0000, 9);
    bmem[idx_addr(bmem[desc_at(1)], va1, 30, 9)] = e;
    bmem[idx_addr(e, va1, 21, 9)] = mk_leaf(64'h00AB_CDEF_5777);
    // tree for pid 2: span 31, widths 16 and 5
    va2 = 64'h0000_0000_5A5A_3C3C;
    bmem[desc_at(2)] = mk_desc(31, 64'h0100_0000, 16);
    e = mk_dir(64'h0200_0000, 5);
    bmem[idx_addr(bmem[desc_at(2)], va2, 31, 16)] = e;
    bmem[idx_addr(e, va2, 15, 5)] = mk_leaf(64'h0012_3456_789A_BCDE);
    // descriptors with bad root widths
    bmem[desc_at(3)] = mk_desc(20, 64'h0800_0000, 4);
    bmem[desc_at(4)] = mk_desc(20, 64'h0800_0000, 17);
    bmem[desc_at(5)] = mk_desc(12, 64'h0800_0000, 16);
    // tree for pid 6: leaf at root level, and a directory with width 4
    va6 = 64'h0000_0000_0ABC_DEF1;
    bmem[desc_at(6)] = mk_desc(28, 64'h0300_0000, 8);
    bmem[idx_addr(bmem[desc_at(6)], va6, 28, 8)] = mk_leaf(64'h0000_0077_7777_7777);
    bmem[idx_addr(bmem[desc_at(6)], va6 ^ 64'h0100_0000, 28, 8)] = mk_dir(64'h0400_0000, 4);
    // tree for pid 7: span 10, widths 5 and 5, shift ends at zero
    va7 = 64'h0000_0000_0000_02D7;
    bmem[desc_at(7)] = mk_desc(10, 64'h0700_0000, 5);
    e = mk_dir(64'h0710_0000, 5);
    bmem[idx_addr(bmem[desc_at(7)], va7, 10, 5)] = e;
    bmem[idx_addr(e, va7, 5, 5)] = mk_leaf(64'h0155_AAAA_0000_0FFF);

    repeat (3) @(negedge clk);
    chk("R1 reset ready", {63'd0, req_ready}, 64'd1);
    chk("R1 reset no read", {63'd0, mem_req}, 64'd0);
    chk("R1 reset no result", {63'd0, res_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {63'd0, req_ready}, 64'd1);

    walk(va1, 1, 1'b0, 1'b0, 1, 1'b0);                      // R3 R6 R7 three levels
    walk(va1, 1, 1'b1, 1'b1, 3, 1'b0);                      // R8 store, problem state
    walk(va1 ^ 64'h0200_0000, 1, 1'b0, 1'b1, 2, 1'b0);      // R5 empty root slot
    walk(va2, 2, 1'b1, 1'b0, 4, 1'b0);                      // R6 widths 16 then 5
    walk(va2 ^ 64'h0000_1000, 2, 1'b0, 1'b0, 1, 1'b0);      // R5 at second level
    walk(va1, 3, 1'b0, 1'b0, 2, 1'b0);                      // R4 root width 4
    walk(va1, 4, 1'b1, 1'b0, 1, 1'b0);                      // R4 root width 17
    walk(va1, 5, 1'b0, 1'b1, 1, 1'b0);                      // R4 width above span
    walk(va6, 6, 1'b0, 1'b0, 2, 1'b0);                      // R7 leaf at root
    walk(va6 ^ 64'h0100_0000, 6, 1'b1, 1'b1, 1, 1'b0);      // R4 deep width 4
    walk(va7, 7, 1'b0, 1'b0, 3, 1'b0);                      // R7 shift reaches zero

    // R9: stray responses while idle have no effect
    spur_go = 1'b1;
    wait (spur_done);
    @(negedge clk);
    chk("R9 idle after stray response", {63'd0, req_ready}, 64'd1);
    chk("R9 no result from stray response", 64'(got_res), 64'd11);
    chk("R9 no read from stray response", {63'd0, mem_req}, 64'd0);

    // R9: a request during a walk is ignored
    walk(va2, 2, 1'b1, 1'b1, 4, 1'b1);
    repeat (4) @(negedge clk);
    chk("R9 intruding request dropped", {63'd0, req_ready}, 64'd1);
    chk("R9 single result for intruded walk", 64'(got_res), 64'd12);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule